// File: doc/BRIEF.md
# Open-Page Idle Timeout and Power-Down Manager

This block follows which DRAM pages are open in each bank of one or two ranks. It gives every open page its own idle countdown, and it decides when pages that have gone idle are closed. It takes each rank's power state into account when making that decision. The command scheduler sends it page-open, page-access and page-close events, each tagged with a rank and a bank. It also receives a powered-down flag per rank, a timing permit and two configuration inputs: the idle timeout value and an opt-in bit for waking a rank on a partial timeout.

The block presents one precharge request at a time on a ready/valid handshake. It raises a wake-up request for a powered-down rank when idle pages there must be closed. For each rank it reports whether a powered-down rank sits in precharge power-down (no page open) or in active power-down (some page open). Command timing, refresh and address decoding belong to other blocks.

Top module: `page_timeout_mgr`

## Requirements
- R1: Each of the 16 trackers (8 banks in each of 2 ranks) holds its own open flag and idle counter. An open or access event loads the counter with `timeout_val_i`. The page counts as timed out once `timeout_val_i` further clock edges have passed without an event. A close event clears the tracker, and it wins over an open or access event to the same bank in the same cycle.
- R2: A new precharge request (`pre_vld_o` = 1 with `pre_rank_o`/`pre_bank_o`) is raised only for a timed-out page, only while `timing_ok_i` = 1, and it appears in the same cycle that the page becomes timed out.
- R3: When several timed-out pages are eligible, the one with the lowest flat index rank*8+bank goes first (lowest rank, then lowest bank).
- R4: Once a request has been shown without `pre_rdy_i`, it stays on the same rank and bank until it is accepted, even if a lower-indexed page times out in the meantime. Acceptance (`pre_vld_o` and `pre_rdy_i` both high on a clock edge) closes that page, so it is not requested again.
- R5: An access to a bank whose close request is pending cancels the timeout and withdraws the request in the next cycle, unless the request has already been accepted.
- R6: Suppose a powered-down rank has some, but not all, of its open pages timed out. Then `wake_o` for that rank is raised only while `partial_wake_en_i` = 1. That input resets low in the surrounding system, which means no wake-up by default.
- R7: When every open page of a powered-down rank has timed out, `wake_o` for that rank rises one cycle later, whatever `partial_wake_en_i` says. Once the rank is awake, all those pages are requested for closing.
- R8: A raised `wake_o` stays high for as long as that rank's `pdown_i` stays high. It falls on the first clock edge that sees `pdown_i` low.
- R9: For a powered-down rank with no open page, `ppd_o` = 1 and `apd_o` = 0. For a powered-down rank with any open page, `apd_o` = 1 and `ppd_o` = 0. For an awake rank both are 0.
- R10: No new precharge request is raised for a rank whose `pdown_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| open_vld_i | input | 1 | Page-open event |
| open_rank_i | input | 1 | Rank of open event |
| open_bank_i | input | 3 | Bank of open event |
| acc_vld_i | input | 1 | Page-access event |
| acc_rank_i | input | 1 | Rank of access event |
| acc_bank_i | input | 3 | Bank of access event |
| close_vld_i | input | 1 | Page-close event |
| close_rank_i | input | 1 | Rank of close event |
| close_bank_i | input | 3 | Bank of close event |
| pdown_i | input | 2 | Per-rank powered-down status |
| timing_ok_i | input | 1 | Permit to issue a new precharge |
| partial_wake_en_i | input | 1 | Opt-in: wake a rank on a partial timeout |
| timeout_val_i | input | 8 | Idle timeout in cycles |
| pre_vld_o | output | 1 | Precharge request valid |
| pre_rdy_i | input | 1 | Precharge request accepted |
| pre_rank_o | output | 1 | Rank of requested precharge |
| pre_bank_o | output | 3 | Bank of requested precharge |
| wake_o | output | 2 | Per-rank wake-up request |
| ppd_o | output | 2 | Per-rank precharge power-down eligible |
| apd_o | output | 2 | Per-rank active power-down |

## Verification
The bench opens single pages and checks the countdown edge by edge, which tells an off-by-one in the counter apart from a correct expiry. It lets several pages expire while the permit is withheld and then releases them together, which separates a priority order from an order of arrival. A separate sequence keeps a request pending while a lower bank expires, which shows that the request is held rather than re-arbitrated. Two powered-down scenarios are also run, one with a partial timeout and one with a full timeout. They separate the opt-in wake path from the unconditional one, and they check the reported power-down flavour against the count of open pages.

// File: rtl/pto_pkg.sv
package pto_pkg;
  typedef enum logic [1:0] {
    PWR_AWAKE  = 2'd0,
    PWR_ACT_PD = 2'd1,
    PWR_PRE_PD = 2'd2
  } pwr_e;

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pto_bank_tracker.sv
module pto_bank_tracker #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] timeout_i,
  output logic             open_o,
  output logic             expired_o
);
  logic             open_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      open_q <= 1'b1;
      cnt_q  <= timeout_i;
    end else if (open_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign open_o    = open_q;
  assign expired_o = open_q && (cnt_q == '0);
endmodule

// File: rtl/pto_rank_policy.sv
module pto_rank_policy #(
  parameter int unsigned BANKS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BANKS-1:0] open_i,
  input  logic [BANKS-1:0] exp_i,
  input  logic             pdown_i,
  input  logic             partial_en_i,
  output logic             wake_o,
  output pto_pkg::pwr_e    pwr_o
);
  logic any_open, any_exp, all_exp, wake_cond, wake_q;

  assign any_open  = |open_i;
  assign any_exp   = |exp_i;
  assign all_exp   = any_open && (exp_i == open_i);
  // full timeout always wakes; partial timeout only when opted in
  assign wake_cond = all_exp || (any_exp && partial_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= pdown_i && (wake_q || wake_cond);
  end

  assign wake_o = wake_q;

  always_comb begin
    if (!pdown_i)      pwr_o = pto_pkg::PWR_AWAKE;
    else if (any_open) pwr_o = pto_pkg::PWR_ACT_PD;
    else               pwr_o = pto_pkg::PWR_PRE_PD;
  end
endmodule

// File: rtl/pto_close_arbiter.sv
module pto_close_arbiter #(
  parameter int unsigned IDX_W = 4,
  localparam int unsigned N    = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     exp_i,
  input  logic [N-1:0]     elig_i,
  input  logic             rdy_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             hold_q;
  logic [IDX_W-1:0] hold_idx_q;
  logic             pick_vld;
  logic [IDX_W-1:0] pick_idx;

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        pick_vld = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end

  // a shown request sticks while its page remains timed out
  always_comb begin
    if (hold_q && exp_i[hold_idx_q]) begin
      vld_o = 1'b1;
      idx_o = hold_idx_q;
    end else begin
      vld_o = pick_vld;
      idx_o = pick_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q     <= vld_o && !rdy_i;
      hold_idx_q <= idx_o;
    end
  end
endmodule

// File: rtl/page_timeout_mgr.sv
module page_timeout_mgr #(
  parameter int unsigned  NUM_RANKS      = 2,
  parameter int unsigned  BANKS_PER_RANK = 8,
  parameter int unsigned  CNT_W          = 8,
  localparam int unsigned RANK_W         = pto_pkg::idx_w(NUM_RANKS),
  localparam int unsigned BANK_W         = pto_pkg::idx_w(BANKS_PER_RANK)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 open_vld_i,
  input  logic [RANK_W-1:0]    open_rank_i,
  input  logic [BANK_W-1:0]    open_bank_i,
  input  logic                 acc_vld_i,
  input  logic [RANK_W-1:0]    acc_rank_i,
  input  logic [BANK_W-1:0]    acc_bank_i,
  input  logic                 close_vld_i,
  input  logic [RANK_W-1:0]    close_rank_i,
  input  logic [BANK_W-1:0]    close_bank_i,
  input  logic [NUM_RANKS-1:0] pdown_i,
  input  logic                 timing_ok_i,
  input  logic                 partial_wake_en_i,
  input  logic [CNT_W-1:0]     timeout_val_i,
  output logic                 pre_vld_o,
  input  logic                 pre_rdy_i,
  output logic [RANK_W-1:0]    pre_rank_o,
  output logic [BANK_W-1:0]    pre_bank_o,
  output logic [NUM_RANKS-1:0] wake_o,
  output logic [NUM_RANKS-1:0] ppd_o,
  output logic [NUM_RANKS-1:0] apd_o
);
  localparam int unsigned IDX_W  = RANK_W + BANK_W;
  localparam int unsigned N_SLOT = 1 << IDX_W;
  localparam int unsigned N_TRK  = NUM_RANKS * BANKS_PER_RANK;

  logic [N_SLOT-1:0] open_vec, exp_vec, elig_vec;
  logic [IDX_W-1:0]  pre_idx;
  logic              pre_fire;

  assign pre_fire   = pre_vld_o && pre_rdy_i;
  assign pre_rank_o = pre_idx[IDX_W-1:BANK_W];
  assign pre_bank_o = pre_idx[BANK_W-1:0];

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    pto_pkg::pwr_e pwr;

    for (genvar b = 0; b < BANKS_PER_RANK; b++) begin : g_bank
      localparam int unsigned IDX = r * BANKS_PER_RANK + b;
      logic hit_open, hit_acc, hit_close, hit_fire;

      assign hit_open  = open_vld_i && open_rank_i == RANK_W'(r) && open_bank_i == BANK_W'(b);
      assign hit_acc   = acc_vld_i && acc_rank_i == RANK_W'(r) && acc_bank_i == BANK_W'(b);
      assign hit_close = close_vld_i && close_rank_i == RANK_W'(r) && close_bank_i == BANK_W'(b);
      assign hit_fire  = pre_fire && pre_idx == IDX_W'(IDX);

      pto_bank_tracker #(.CNT_W(CNT_W)) i_trk (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (hit_open || hit_acc),
        .clear_i   (hit_close || hit_fire),
        .timeout_i (timeout_val_i),
        .open_o    (open_vec[IDX]),
        .expired_o (exp_vec[IDX])
      );

      assign elig_vec[IDX] = exp_vec[IDX] && !pdown_i[r] && timing_ok_i;
    end

    pto_rank_policy #(.BANKS(BANKS_PER_RANK)) i_pol (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .open_i       (open_vec[r*BANKS_PER_RANK +: BANKS_PER_RANK]),
      .exp_i        (exp_vec[r*BANKS_PER_RANK +: BANKS_PER_RANK]),
      .pdown_i      (pdown_i[r]),
      .partial_en_i (partial_wake_en_i),
      .wake_o       (wake_o[r]),
      .pwr_o        (pwr)
    );

    assign ppd_o[r] = (pwr == pto_pkg::PWR_PRE_PD);
    assign apd_o[r] = (pwr == pto_pkg::PWR_ACT_PD);
  end

  if (N_SLOT > N_TRK) begin : g_pad
    assign open_vec[N_SLOT-1:N_TRK] = '0;
    assign exp_vec[N_SLOT-1:N_TRK]  = '0;
    assign elig_vec[N_SLOT-1:N_TRK] = '0;
  end

  pto_close_arbiter #(.IDX_W(IDX_W)) i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .exp_i  (exp_vec),
    .elig_i (elig_vec),
    .rdy_i  (pre_rdy_i),
    .vld_o  (pre_vld_o),
    .idx_o  (pre_idx)
  );
endmodule

// File: rtl/page_timeout_mgr_chk.sv
module page_timeout_mgr_chk #(
  parameter int unsigned  NUM_RANKS      = 2,
  parameter int unsigned  BANKS_PER_RANK = 8,
  parameter int unsigned  CNT_W          = 8,
  localparam int unsigned RANK_W         = pto_pkg::idx_w(NUM_RANKS),
  localparam int unsigned BANK_W         = pto_pkg::idx_w(BANKS_PER_RANK)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 open_vld_i,
  input logic [RANK_W-1:0]    open_rank_i,
  input logic [BANK_W-1:0]    open_bank_i,
  input logic                 acc_vld_i,
  input logic [RANK_W-1:0]    acc_rank_i,
  input logic [BANK_W-1:0]    acc_bank_i,
  input logic                 close_vld_i,
  input logic [RANK_W-1:0]    close_rank_i,
  input logic [BANK_W-1:0]    close_bank_i,
  input logic [NUM_RANKS-1:0] pdown_i,
  input logic                 timing_ok_i,
  input logic                 partial_wake_en_i,
  input logic [CNT_W-1:0]     timeout_val_i,
  input logic                 pre_vld_o,
  input logic                 pre_rdy_i,
  input logic [RANK_W-1:0]    pre_rank_o,
  input logic [BANK_W-1:0]    pre_bank_o,
  input logic [NUM_RANKS-1:0] wake_o,
  input logic [NUM_RANKS-1:0] ppd_o,
  input logic [NUM_RANKS-1:0] apd_o
);
  logic [RANK_W+BANK_W-1:0] req_idx;
  logic                     req_hit;

  assign req_idx = {pre_rank_o, pre_bank_o};
  assign req_hit = (open_vld_i  && {open_rank_i, open_bank_i}   == req_idx) ||
                   (acc_vld_i   && {acc_rank_i, acc_bank_i}     == req_idx) ||
                   (close_vld_i && {close_rank_i, close_bank_i} == req_idx);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_vld_o && !pre_rdy_i && !req_hit |=> pre_vld_o && $stable(pre_rank_o) && $stable(pre_bank_o));

  assert_accept_closes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_vld_o && pre_rdy_i |=> !(pre_vld_o && req_idx == $past(req_idx)));

  assert_new_req_awake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pre_vld_o) |-> !pdown_i[pre_rank_o] && timing_ok_i);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rk
    assert_wake_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o[r] && pdown_i[r] |=> wake_o[r]);

    assert_wake_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pdown_i[r] |=> !wake_o[r]);

    assert_pd_report_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ppd_o[r] || apd_o[r]) == pdown_i[r]) && !(ppd_o[r] && apd_o[r]));
  end
endmodule

bind page_timeout_mgr page_timeout_mgr_chk #(
  .NUM_RANKS      (NUM_RANKS),
  .BANKS_PER_RANK (BANKS_PER_RANK),
  .CNT_W          (CNT_W)
) i_chk (.*);

// File: tb/test_page_timeout_mgr.sv
`timescale 1ns/1ps
module test_page_timeout_mgr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       open_vld, acc_vld, close_vld;
  logic       open_rank, acc_rank, close_rank;
  logic [2:0] open_bank, acc_bank, close_bank;
  logic [1:0] pdown;
  logic       timing_ok, partial_en, pre_rdy;
  logic [7:0] tmo;
  logic       pre_vld, pre_rank;
  logic [2:0] pre_bank;
  logic [1:0] wake, ppd, apd;

  int vectors = 0;
  int miscompares = 0;
  logic [3:0] sb_q[$];

  always #2 clk = ~clk;

  page_timeout_mgr i_page_timeout_mgr (
    .clk_i(clk), .rst_ni(rst_n),
    .open_vld_i(open_vld), .open_rank_i(open_rank), .open_bank_i(open_bank),
    .acc_vld_i(acc_vld), .acc_rank_i(acc_rank), .acc_bank_i(acc_bank),
    .close_vld_i(close_vld), .close_rank_i(close_rank), .close_bank_i(close_bank),
    .pdown_i(pdown), .timing_ok_i(timing_ok), .partial_wake_en_i(partial_en),
    .timeout_val_i(tmo), .pre_vld_o(pre_vld), .pre_rdy_i(pre_rdy),
    .pre_rank_o(pre_rank), .pre_bank_o(pre_bank),
    .wake_o(wake), .ppd_o(ppd), .apd_o(apd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // kind: 0 open, 1 access, 2 close
  task automatic ev(input int kind, input logic r, input logic [2:0] b);
    case (kind)
      0: begin open_vld = 1'b1; open_rank = r; open_bank = b; end
      1: begin acc_vld = 1'b1; acc_rank = r; acc_bank = b; end
      default: begin close_vld = 1'b1; close_rank = r; close_bank = b; end
    endcase
    step(1);
    open_vld = 1'b0; acc_vld = 1'b0; close_vld = 1'b0;
  endtask

  // monitor: every handshake must match the next expected rank/bank
  always @(negedge clk) begin
    if (rst_n && pre_vld && pre_rdy) begin
      vectors++;
      if (sb_q.size() == 0) begin
        miscompares++;
        $display("FAIL R3: got %0d expected none (unexpected precharge)", {pre_rank, pre_bank});
      end else begin
        logic [3:0] e;
        e = sb_q.pop_front();
        if ({pre_rank, pre_bank} !== e) begin
          miscompares++;
          $display("FAIL R3: got %0d expected %0d", {pre_rank, pre_bank}, e);
        end
      end
    end
  end

  initial begin
    #800000;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    open_vld = 0; acc_vld = 0; close_vld = 0;
    open_rank = 0; acc_rank = 0; close_rank = 0;
    open_bank = 0; acc_bank = 0; close_bank = 0;
    pdown = 2'b00; timing_ok = 1'b1; partial_en = 1'b0; pre_rdy = 1'b0; tmo = 8'd4;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R2 reset pre_vld", pre_vld, 0);
    chk("R8 reset wake", wake, 0);
    chk("R9 reset ppd", ppd, 0);
    chk("R9 reset apd", apd, 0);

    // R1 countdown and R2 request
    tmo = 8'd4;
    ev(0, 1'b0, 3'd2);
    step(3);
    chk("R1 not yet expired", pre_vld, 0);
    step(1);
    chk("R1 expired after timeout", pre_vld, 1);
    chk("R2 request rank/bank", {pre_rank, pre_bank}, 4'd2);
    sb_q.push_back(4'd2);
    pre_rdy = 1'b1;
    step(1);
    pre_rdy = 1'b0;
    chk("R4 accepted page closed", pre_vld, 0);

    // R3 priority among pages released together
    timing_ok = 1'b0;
    tmo = 8'd1;
    ev(0, 1'b1, 3'd0);
    ev(0, 1'b0, 3'd5);
    ev(0, 1'b0, 3'd3);
    step(2);
    chk("R2 no request without permit", pre_vld, 0);
    sb_q.push_back(4'd3);
    sb_q.push_back(4'd5);
    sb_q.push_back(4'd8);
    timing_ok = 1'b1;
    pre_rdy = 1'b1;
    step(3);
    pre_rdy = 1'b0;
    chk("R3 all drained in order", sb_q.size(), 0);
    chk("R3 idle after drain", pre_vld, 0);

    // R4 hold against a lower bank expiring
    tmo = 8'd1;
    ev(0, 1'b1, 3'd1);
    step(2);
    tmo = 8'd0;
    ev(0, 1'b0, 3'd0);
    chk("R4 held valid", pre_vld, 1);
    chk("R4 held rank/bank", {pre_rank, pre_bank}, 4'd9);
    sb_q.push_back(4'd9);
    sb_q.push_back(4'd0);
    pre_rdy = 1'b1;
    step(2);
    pre_rdy = 1'b0;
    chk("R4 both accepted", sb_q.size(), 0);

    // R5 access withdraws a pending request
    tmo = 8'd1;
    ev(0, 1'b0, 3'd6);
    step(1);
    chk("R5 request pending", {pre_vld, pre_rank, pre_bank}, 5'b1_0110);
    ev(1, 1'b0, 3'd6);
    chk("R5 withdrawn after access", pre_vld, 0);
    ev(2, 1'b0, 3'd6);
    step(2);
    chk("R1 close clears tracker", pre_vld, 0);

    // R6 partial timeout in powered-down rank 1
    pdown = 2'b10;
    tmo = 8'd2;
    ev(0, 1'b1, 3'd2);
    tmo = 8'd200;
    ev(0, 1'b1, 3'd3);
    step(3);
    chk("R6 no wake without opt-in", wake[1], 0);
    chk("R10 no request while powered down", pre_vld, 0);
    chk("R9 active power-down", {ppd[1], apd[1]}, 2'b01);
    partial_en = 1'b1;
    step(1);
    chk("R6 wake with opt-in", wake[1], 1);
    partial_en = 1'b0;
    step(2);
    chk("R8 wake held while powered down", wake[1], 1);
    sb_q.push_back(4'd10);
    pre_rdy = 1'b1;
    pdown = 2'b00;
    step(1);
    pre_rdy = 1'b0;
    chk("R8 wake dropped after power-up", wake[1], 0);
    chk("R6 timed-out page closed", sb_q.size(), 0);
    chk("R9 awake reports none", {ppd, apd}, 4'b0000);
    ev(2, 1'b1, 3'd3);

    // R7 full timeout in powered-down rank 0
    pdown = 2'b01;
    partial_en = 1'b0;
    tmo = 8'd2;
    ev(0, 1'b0, 3'd1);
    ev(0, 1'b0, 3'd4);
    step(3);
    chk("R7 wake on full timeout", wake[0], 1);
    chk("R9 active power-down rank 0", {ppd[0], apd[0]}, 2'b01);
    chk("R10 no request before wake", pre_vld, 0);
    sb_q.push_back(4'd1);
    sb_q.push_back(4'd4);
    pre_rdy = 1'b1;
    pdown = 2'b00;
    step(2);
    pre_rdy = 1'b0;
    chk("R7 all pages closed", sb_q.size(), 0);
    pdown = 2'b01;
    step(1);
    chk("R9 precharge power-down", {ppd[0], apd[0]}, 2'b10);
    chk("R7 no wake with nothing open", wake[0], 0);
    pdown = 2'b00;
    step(2);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule